// File: doc/BRIEF.md
# SMBus Host Controller Register Front End

This block is the register layer that firmware talks to when it drives an SMBus host controller. It sits between a simple register bus (address, write data, registered read data, one-cycle read and write strobes) and a separate bus-protocol engine, which does the bit-level work. Firmware sets an I/O base and an enable bit in a configuration register, clears old status, writes the start bit, polls the busy flag until it falls, checks the error flags, and then reads back any received bytes.

Received bytes go into a 32-entry buffer as the engine delivers them. After a block read, firmware first reads the byte count. It then reads the same index port again and again, and each read returns the next byte in arrival order. The status register combines a busy flag that hardware drives with write-one-to-clear flags for completion, no-acknowledge or bad target response, bus collision, CRC error and last byte received.

Top module: `smb_host_regs`

## Requirements
- R1: After reset the status register reads 0x00, the byte count reads 0, the control register reads 0, and the configuration register reads 0xFFF0 (base all ones, controller disabled).
- R2: The register map is: address 0 status, 1 control, 2 byte count, 3 indexed data port, 4 configuration. Any other address reads 0. Read data appears on `rdata` one cycle after the `rd_en` strobe and holds until the next read.
- R3: A write to control with bit 6 set, while the controller is enabled and status bit 0 (busy) is 0, drives `eng_start` high for exactly the one cycle after the write. From that cycle on, busy reads 1. The start bit always reads back 0.
- R4: A start write is ignored, with no pulse and no change of state, while the controller is disabled or busy.
- R5: On an `eng_done` pulse, busy clears and status bit 1 (interrupt) sets in the same cycle. `eng_dev_err` latches into bit 2, `eng_coll_err` into bit 3 and `eng_crc_err` into bit 4.
- R6: Status bits 1, 2, 3, 4 and 7 are cleared by writing 1 to them. Writing 0 leaves them unchanged. Writes never alter bit 0. Bits 6:5 always read 0.
- R7: If a hardware set and a software clear hit the same status bit in the same cycle, the set wins.
- R8: While busy, each `eng_rx_valid` stores `eng_rx_byte` and increments the byte count. A byte flagged with `eng_rx_last` sets status bit 7. Bytes that arrive while the controller is idle are ignored. Bytes beyond 32 are dropped, and the count saturates at 32.
- R9: Reads of the index port return the stored bytes in arrival order, one per read. Once all stored bytes have been read, the port returns 0. An accepted start resets the byte count and the read pointer to 0.
- R10: In the configuration register, bit 0 is the enable, bits 15:4 are the I/O base, and bits 3:1 read 0. Both fields appear at the `cfg_enable` and `io_base` outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| rdata | output | 16 | Registered read data |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_dev_err | input | 1 | No acknowledge or bad target response, qualified by done |
| eng_coll_err | input | 1 | Bus collision, qualified by done |
| eng_crc_err | input | 1 | CRC error, qualified by done |
| eng_rx_valid | input | 1 | Received byte strobe |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_last | input | 1 | Marks the last received byte |
| cfg_enable | output | 1 | Controller enable |
| io_base | output | 12 | I/O base address |

## Verification
Every result is due exactly one clock edge after its cause. Register contents, `eng_start`, busy and the interrupt flag all change at the edge that samples a write strobe, a done pulse or a received byte, and `rdata` changes at the edge that samples `rd_en`. The bench drives every strobe for one cycle starting at a falling edge and samples at the next falling edge, half a period after the edge that is due. The one-cycle start pulse is sampled twice: at that falling edge, where it must be high, and one cycle later, where it must be low.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_INDEX  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CFG    = 3'd4;

  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_INTR = 1;
  localparam int unsigned ST_DEV  = 2;
  localparam int unsigned ST_COLL = 3;
  localparam int unsigned ST_CRC  = 4;
  localparam int unsigned ST_LAST = 7;

  localparam logic [7:0] W1C_MASK = 8'h9E;
  localparam int unsigned CTRL_START_BIT = 6;
endpackage

// File: rtl/smb_start_ctl.sv
module smb_start_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic start_bit,
  input  logic enable,
  input  logic busy,
  output logic start_accept,
  output logic eng_start
);
  logic start_d;

  always_comb begin
    start_accept = wr_ctrl && start_bit && enable && !busy;
    start_d      = start_accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eng_start <= 1'b0;
    else        eng_start <= start_d;
  end
endmodule

// File: rtl/smb_status_reg.sv
module smb_status_reg
  import smb_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_accept,
  input  logic       done,
  input  logic       dev_err,
  input  logic       coll_err,
  input  logic       crc_err,
  input  logic       last_set,
  input  logic       wr_stat,
  input  logic [7:0] wdata,
  output logic [7:0] stat_q
);
  logic [7:0] clr_mask;
  logic [7:0] set_mask;
  logic [7:0] stat_d;
  logic       stat_en;

  always_comb begin
    clr_mask = wr_stat ? (wdata & W1C_MASK) : 8'h00;
    set_mask = 8'h00;
    set_mask[ST_INTR] = done;
    set_mask[ST_DEV]  = done && dev_err;
    set_mask[ST_COLL] = done && coll_err;
    set_mask[ST_CRC]  = done && crc_err;
    set_mask[ST_LAST] = last_set;
    stat_d = (stat_q & ~clr_mask) | set_mask;
    stat_d[6:5] = 2'b00;
    if (start_accept)  stat_d[ST_BUSY] = 1'b1;
    else if (done)     stat_d[ST_BUSY] = 1'b0;
    else               stat_d[ST_BUSY] = stat_q[ST_BUSY];
    stat_en = wr_stat || start_accept || done || last_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= 8'h00;
    else if (stat_en) stat_q <= stat_d;
  end
endmodule

// File: rtl/smb_rx_buffer.sv
module smb_rx_buffer #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW    = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [7:0]    push_byte,
  input  logic          pop,
  output logic [7:0]    pop_byte,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] count_d;
  logic [CW-1:0] ptr_q;
  logic [CW-1:0] ptr_d;
  logic          wr_ok;
  logic          cnt_en;
  logic          ptr_en;

  always_comb begin
    wr_ok   = push && (count < FULL);
    count_d = clear ? '0 : count + CW'(1);
    cnt_en  = clear || wr_ok;
    ptr_d   = clear ? '0 : ptr_q + CW'(1);
    ptr_en  = clear || (pop && (ptr_q < FULL));
    pop_byte = (ptr_q < count) ? mem[ptr_q[IDX_W-1:0]] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (wr_ok && !clear) mem[count[IDX_W-1:0]] <= push_byte;
  end
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_regs_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned BASE_W = DW - 4,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DW-1:0]     rdata,
  output logic              eng_start,
  input  logic              eng_done,
  input  logic              eng_dev_err,
  input  logic              eng_coll_err,
  input  logic              eng_crc_err,
  input  logic              eng_rx_valid,
  input  logic [7:0]        eng_rx_byte,
  input  logic              eng_rx_last,
  output logic              cfg_enable,
  output logic [BASE_W-1:0] io_base
);
  logic [1:0]    rst_sync;
  logic          rst_n_i;
  logic [7:0]    stat_q;
  logic          start_accept;
  logic          rx_accept;
  logic [7:0]    idx_byte;
  logic [CW-1:0] rx_count;
  logic          wr_stat;
  logic          wr_ctrl;
  logic          wr_cfg;
  logic          rd_idx;
  logic [DW-1:0] rd_mux;
  logic          unused_cfg_bits;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  always_comb begin
    wr_stat   = wr_en && (addr == A_STATUS);
    wr_ctrl   = wr_en && (addr == A_CTRL);
    wr_cfg    = wr_en && (addr == A_CFG);
    rd_idx    = rd_en && (addr == A_INDEX);
    rx_accept = eng_rx_valid && stat_q[ST_BUSY];
  end
  assign unused_cfg_bits = ^wdata[3:1];

  smb_start_ctl u_start (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .wr_ctrl      (wr_ctrl),
    .start_bit    (wdata[CTRL_START_BIT]),
    .enable       (cfg_enable),
    .busy         (stat_q[ST_BUSY]),
    .start_accept (start_accept),
    .eng_start    (eng_start)
  );

  smb_status_reg u_status (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .start_accept (start_accept),
    .done         (eng_done),
    .dev_err      (eng_dev_err),
    .coll_err     (eng_coll_err),
    .crc_err      (eng_crc_err),
    .last_set     (rx_accept && eng_rx_last),
    .wr_stat      (wr_stat),
    .wdata        (wdata[7:0]),
    .stat_q       (stat_q)
  );

  smb_rx_buffer #(.DEPTH(DEPTH)) u_rxbuf (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .clear     (start_accept),
    .push      (rx_accept),
    .push_byte (eng_rx_byte),
    .pop       (rd_idx),
    .pop_byte  (idx_byte),
    .count     (rx_count)
  );

  // configuration register
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cfg_enable <= 1'b0;
      io_base    <= '1;
    end else if (wr_cfg) begin
      cfg_enable <= wdata[0];
      io_base    <= wdata[DW-1:4];
    end
  end

  always_comb begin
    case (addr)
      A_STATUS: rd_mux = {{(DW-8){1'b0}}, stat_q};
      A_COUNT:  rd_mux = {{(DW-CW){1'b0}}, rx_count};
      A_INDEX:  rd_mux = {{(DW-8){1'b0}}, idx_byte};
      A_CFG:    rd_mux = {io_base, 3'b000, cfg_enable};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)   rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eng_start,
  input logic          eng_done,
  input logic          enable,
  input logic [7:0]    stat_q,
  input logic [CW-1:0] rx_count
);
  a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  a_r3_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> stat_q[0]);

  a_r4_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(enable));

  a_r5_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && stat_q[0]) |=> !stat_q[0]);

  a_r5_done_sets_intr: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> stat_q[1]);

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[6:5] == 2'b00);

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  a_r9_start_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (rx_count == '0));
endmodule

bind smb_host_regs smb_host_regs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .eng_start (eng_start),
  .eng_done  (eng_done),
  .enable    (cfg_enable),
  .stat_q    (stat_q),
  .rx_count  (rx_count)
);

// File: tb/tb_smb_host_regs.sv
`timescale 1ns/1ps
module tb_smb_host_regs;
  logic        clk;
  logic        rst_n;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic        wr_en;
  logic        rd_en;
  logic [15:0] rdata;
  logic        eng_start;
  logic        eng_done;
  logic        eng_dev_err;
  logic        eng_coll_err;
  logic        eng_crc_err;
  logic        eng_rx_valid;
  logic [7:0]  eng_rx_byte;
  logic        eng_rx_last;
  logic        cfg_enable;
  logic [11:0] io_base;

  int checks = 0;
  int errors = 0;
  logic [15:0] rv;

  smb_host_regs dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [2:0]  a;
    logic [15:0] d;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 16'h0000, 16'h0000},  // R1 status
    '{1'b0, 3'd4, 16'h0000, 16'hFFF0},  // R1 config
    '{1'b0, 3'd2, 16'h0000, 16'h0000},  // R1 count
    '{1'b0, 3'd1, 16'h0000, 16'h0000},  // R1 control
    '{1'b1, 3'd4, 16'h1235, 16'h0000},
    '{1'b0, 3'd4, 16'h0000, 16'h1231},  // R10 bits 3:1 read 0
    '{1'b0, 3'd7, 16'h0000, 16'h0000},  // R2 unmapped address
    '{1'b0, 3'd5, 16'h0000, 16'h0000},  // R2 unmapped address
    '{1'b1, 3'd0, 16'hFFFF, 16'h0000},
    '{1'b0, 3'd0, 16'h0000, 16'h0000}   // R6 writes cannot set bits
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rx(input logic [7:0] b, input logic last);
    @(negedge clk);
    eng_rx_valid = 1'b1; eng_rx_byte = b; eng_rx_last = last;
    @(negedge clk);
    eng_rx_valid = 1'b0; eng_rx_last = 1'b0;
  endtask

  task automatic done(input logic dev, input logic coll, input logic crc);
    @(negedge clk);
    eng_done = 1'b1; eng_dev_err = dev; eng_coll_err = coll; eng_crc_err = crc;
    @(negedge clk);
    eng_done = 1'b0; eng_dev_err = 1'b0; eng_coll_err = 1'b0; eng_crc_err = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    addr = '0; wdata = '0; wr_en = 0; rd_en = 0;
    eng_done = 0; eng_dev_err = 0; eng_coll_err = 0; eng_crc_err = 0;
    eng_rx_valid = 0; eng_rx_byte = '0; eng_rx_last = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 eng_start in reset", {15'd0, eng_start}, 16'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R10 io_base after reset", {4'd0, io_base}, 16'h0FFF);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_wr(VECS[i].a, VECS[i].d);
      else begin
        bus_rd(VECS[i].a, rv);
        chk($sformatf("R1/R2/R6/R10 vector %0d", i), rv, VECS[i].exp);
      end
    end
    chk("R10 io_base output", {4'd0, io_base}, 16'h0123);
    chk("R10 enable output", {15'd0, cfg_enable}, 16'd1);

    // R4: start while disabled is ignored
    bus_wr(3'd4, 16'h1230);
    bus_wr(3'd1, 16'h0040);
    chk("R4 no start while disabled", {15'd0, eng_start}, 16'd0);
    bus_rd(3'd0, rv);
    chk("R4 busy stays 0 while disabled", rv, 16'h0000);

    // R3: write without bit 6 does nothing; with bit 6 starts
    bus_wr(3'd4, 16'h1231);
    bus_wr(3'd1, 16'h00BF);
    chk("R3 no start without bit 6", {15'd0, eng_start}, 16'd0);
    bus_wr(3'd1, 16'h0040);
    chk("R3 start pulse high", {15'd0, eng_start}, 16'd1);
    @(negedge clk);
    chk("R3 start pulse one cycle", {15'd0, eng_start}, 16'd0);
    bus_rd(3'd0, rv);
    chk("R3 busy set", rv, 16'h0001);
    bus_rd(3'd1, rv);
    chk("R3 start bit reads 0", rv, 16'h0000);
    bus_wr(3'd1, 16'h0040);
    chk("R4 no start while busy", {15'd0, eng_start}, 16'd0);

    // R8: receive bytes
    rx(8'hAA, 1'b0);
    rx(8'hBB, 1'b0);
    rx(8'hCC, 1'b1);
    bus_rd(3'd2, rv);
    chk("R8 count after three bytes", rv, 16'd3);
    bus_rd(3'd0, rv);
    chk("R8 last-byte bit set", rv, 16'h0081);

    // R5: done with device and CRC errors
    done(1'b1, 1'b0, 1'b1);
    bus_rd(3'd0, rv);
    chk("R5 done status", rv, 16'h0096);

    // R9: indexed reads
    bus_rd(3'd3, rv); chk("R9 index byte 0", rv, 16'h00AA);
    bus_rd(3'd3, rv); chk("R9 index byte 1", rv, 16'h00BB);
    bus_rd(3'd3, rv); chk("R9 index byte 2", rv, 16'h00CC);
    bus_rd(3'd3, rv); chk("R9 index past count", rv, 16'h0000);

    // R6: write-one-to-clear
    bus_wr(3'd0, 16'h0004);
    bus_rd(3'd0, rv); chk("R6 clear bit 2 only", rv, 16'h0092);
    bus_wr(3'd0, 16'h0000);
    bus_rd(3'd0, rv); chk("R6 zero write no effect", rv, 16'h0092);
    bus_wr(3'd0, 16'h00FF);
    bus_rd(3'd0, rv); chk("R6 clear all", rv, 16'h0000);

    // R8: bytes while idle are ignored
    rx(8'h55, 1'b1);
    bus_rd(3'd2, rv); chk("R8 idle byte ignored (count)", rv, 16'd3);
    bus_rd(3'd0, rv); chk("R8 idle byte ignored (status)", rv, 16'h0000);

    // R9: new start clears count; R8 overflow
    bus_wr(3'd1, 16'h0040);
    bus_rd(3'd2, rv); chk("R9 start clears count", rv, 16'd0);
    for (int k = 0; k < 34; k++) rx(8'(k + 16), 1'b0);
    bus_rd(3'd2, rv); chk("R8 count saturates at 32", rv, 16'd32);
    bus_rd(3'd3, rv); chk("R9 new pointer first byte", rv, 16'h0010);
    for (int k = 1; k < 31; k++) bus_rd(3'd3, rv);
    bus_rd(3'd3, rv); chk("R8 32nd byte kept", rv, 16'h002F);
    bus_rd(3'd3, rv); chk("R8 overflow bytes dropped", rv, 16'h0000);

    // R7: done together with a clear of the interrupt bit
    @(negedge clk);
    eng_done = 1'b1; eng_coll_err = 1'b1;
    addr = 3'd0; wdata = 16'h000A; wr_en = 1'b1;
    @(negedge clk);
    eng_done = 1'b0; eng_coll_err = 1'b0; wr_en = 1'b0;
    bus_rd(3'd0, rv); chk("R7 set wins over clear", rv, 16'h000A);

    finish_run();
  end
endmodule